// File: doc/BRIEF.md
# Dynamic on-die termination selector

This block decides, clock by clock, which termination setting a memory device applies to its data bus. It holds three 3-bit termination codes: one for normal operation with the termination pin asserted, one for the duration of a write burst, and a fallback used while the pin is deasserted. The termination pin works through separate turn-on and turn-off delays. Each accepted write command schedules two timed events: a switch to the write code a fixed number of clocks later, and a return to the pin-driven choice some clocks after that.

The open delay is the write latency minus two. The window length depends on the burst kind: four clocks for a chopped burst and six for a full burst. A 2-clock write preamble adds one clock and write CRC adds one more. The burst kind can be fixed by configuration or picked per command. Writes that overlap merge into a single window. A zero write code, an off DLL or an illegal latency setting keeps the write code from being applied.

Top module: `dodt_sel`

## Requirements
- R1: The source tag `rtt_src_o` uses 2'b00 off, 2'b01 nominal, 2'b10 write, 2'b11 park. `rtt_code_o` carries the code of the selected source. Outside a write window the delayed pin chooses nominal when high and park when low.
- R2: After reset, no write window is pending and nominal termination is off, so the park source is reported.
- R3: Let the pin be sampled high at edge k. Nominal termination is reported from edge k+`cfg_on_lat` onward. Let the pin be sampled low at edge m. Nominal termination stops at edge m+`cfg_off_lat`.
- R4: Let a write command be sampled at edge k. The write source is reported from edge k+WL−2, where WL is `cfg_wlat`.
- R5: The write source ends at edge k+WL−2+4 for a chopped burst and at edge k+WL−2+6 for a full burst.
- R6: `cfg_burst_mode` selects the burst kind: 2'b00 always full burst, 2'b01 always chopped, 2'b1x per command, where `wr_bc4`=1 means chopped.
- R7: `cfg_pre2_en` adds one clock to the window end and `cfg_crc_en` adds one clock; the two add together.
- R8: When a second write arrives before the window closes, the write source stays on without a gap. It ends at the later of the two end edges.
- R9: A write sampled while `cfg_wr_code` is 3'b000 schedules no window.
- R10: While `cfg_dll_off` is high, pending and open windows are cleared at the next edge and writes schedule nothing.
- R11: `cfg_err_o` is high when WL lies outside WL_MIN..WL_MAX (5..24 by default), when `cfg_on_lat` > `cfg_off_lat`, or when `cfg_off_lat` > LAT_MAX (24). Writes sampled while it is high are ignored.
- R12: When the selected source's code is 3'b000, the tag reports off and the code is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nom_code | input | 3 | Nominal termination code |
| cfg_wr_code | input | 3 | Write termination code; zero disables the feature |
| cfg_park_code | input | 3 | Park termination code |
| cfg_wlat | input | 6 | Write latency in clocks |
| cfg_burst_mode | input | 2 | Burst kind selection |
| cfg_crc_en | input | 1 | Write CRC enabled |
| cfg_pre2_en | input | 1 | 2-clock write preamble enabled |
| cfg_dll_off | input | 1 | DLL-off operation |
| cfg_on_lat | input | 5 | Pin turn-on delay |
| cfg_off_lat | input | 5 | Pin turn-off delay |
| wr_cmd | input | 1 | Write command strobe, any write variant |
| wr_bc4 | input | 1 | Per-command chopped-burst flag |
| odt_pin | input | 1 | Termination control pin |
| rtt_code_o | output | 3 | Active termination code |
| rtt_src_o | output | 2 | Selected source tag |
| cfg_err_o | output | 1 | Illegal latency configuration |

## Verification
Single writes are issued with full bursts, with fixed chopped bursts, and with per-command selection in both directions. This separates the burst decode from the per-command flag. Two write latencies and the preamble and CRC combinations confirm that the open and close edges track the formula and that the extra clocks add. Overlapping writes are issued as a later-ending pair and as a pair where the second write ends sooner, which separates merge-to-the-later-end from restart-on-the-last-write. DLL-off, a zero write code, illegal latencies and zero nominal or park codes each show whether the window is suppressed and whether the off tag is reported.

// File: rtl/dodt_pkg.sv
`timescale 1ns/1ps
package dodt_pkg;
    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_NOM  = 2'd1,
        SRC_WR   = 2'd2,
        SRC_PARK = 2'd3
    } rtt_src_e;

    typedef enum logic [1:0] {
        BM_BL8     = 2'd0,
        BM_BC4     = 2'd1,
        BM_OTF     = 2'd2,
        BM_OTF_ALT = 2'd3
    } burst_mode_e;
endpackage

// File: rtl/dodt_lat_calc.sv
`timescale 1ns/1ps
module dodt_lat_calc #(
    parameter int WL_W    = 6,
    parameter int LAT_W   = 5,
    parameter int WL_MIN  = 5,
    parameter int WL_MAX  = 24,
    parameter int LAT_MAX = 24,
    parameter int CNT_W   = 6
) (
    input  logic [WL_W-1:0]  cfg_wlat,
    input  logic [1:0]       cfg_burst_mode,
    input  logic             wr_bc4,
    input  logic             cfg_crc_en,
    input  logic             cfg_pre2_en,
    input  logic [LAT_W-1:0] cfg_on_lat,
    input  logic [LAT_W-1:0] cfg_off_lat,
    output logic [CNT_W-1:0] open_lat,
    output logic [CNT_W-1:0] close_lat,
    output logic             cfg_err
);
    import dodt_pkg::*;

    localparam logic [WL_W-1:0]  WL_MIN_V  = WL_MIN[WL_W-1:0];
    localparam logic [WL_W-1:0]  WL_MAX_V  = WL_MAX[WL_W-1:0];
    localparam logic [LAT_W-1:0] LAT_MAX_V = LAT_MAX[LAT_W-1:0];

    logic             wl_ok;
    logic             lat_ok;
    logic             is_chop;
    logic [CNT_W-1:0] tail;

    always_comb begin
        wl_ok  = (cfg_wlat >= WL_MIN_V) && (cfg_wlat <= WL_MAX_V);
        lat_ok = (cfg_on_lat <= cfg_off_lat) && (cfg_off_lat <= LAT_MAX_V);
        case (burst_mode_e'(cfg_burst_mode))
            BM_BL8:  is_chop = 1'b0;
            BM_BC4:  is_chop = 1'b1;
            default: is_chop = wr_bc4;
        endcase
        tail = is_chop ? CNT_W'(4) : CNT_W'(6);
        if (wl_ok) begin
            open_lat  = CNT_W'(cfg_wlat) - CNT_W'(2);
        end else begin
            open_lat  = CNT_W'(1);
        end
        close_lat = open_lat + tail + CNT_W'(cfg_pre2_en) + CNT_W'(cfg_crc_en);
        cfg_err   = !(wl_ok && lat_ok);
    end
endmodule

// File: rtl/dodt_pin_delay.sv
`timescale 1ns/1ps
module dodt_pin_delay #(
    parameter int LAT_W   = 5,
    parameter int LAT_MAX = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             odt_pin,
    input  logic [LAT_W-1:0] cfg_on_lat,
    input  logic [LAT_W-1:0] cfg_off_lat,
    output logic             nom_on
);
    localparam int HIST = (LAT_MAX < 2) ? 2 : LAT_MAX;

    typedef struct packed {
        logic [HIST-1:0] hist;
        logic            nom;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    del_on;
    logic    del_off;

    always_comb begin
        del_on  = (cfg_on_lat == '0)  ? odt_pin : 1'b0;
        del_off = (cfg_off_lat == '0) ? odt_pin : 1'b0;
        for (int i = 0; i < HIST; i++) begin
            if (cfg_on_lat == LAT_W'(i + 1))  del_on  = st_q.hist[i];
            if (cfg_off_lat == LAT_W'(i + 1)) del_off = st_q.hist[i];
        end
        st_d      = st_q;
        st_d.hist = (st_q.hist << 1) | HIST'(odt_pin);
        st_d.nom  = del_on | (st_q.nom & del_off);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nom_on = st_q.nom;

    AST_NOM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.nom) |-> $past(del_on)); // R3
    AST_NOM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.nom) |-> !$past(del_off)); // R3
endmodule

// File: rtl/dodt_wr_window.sv
`timescale 1ns/1ps
module dodt_wr_window #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             flush,
    input  logic [CNT_W-1:0] open_lat,
    input  logic [CNT_W-1:0] close_lat,
    output logic             win_act
);
    typedef struct packed {
        logic [DEPTH-1:0] start;
        logic [CNT_W-1:0] rem;
        logic             act;
    } win_st_t;

    win_st_t          st_d, st_q;
    logic [CNT_W-1:0] rem_dec;

    always_comb begin
        rem_dec    = (st_q.rem != '0) ? st_q.rem - CNT_W'(1) : '0;
        st_d       = st_q;
        st_d.start = st_q.start >> 1;
        st_d.rem   = rem_dec;
        st_d.act   = st_q.start[0] | (st_q.act & (st_q.rem > CNT_W'(1)));
        if (fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (open_lat == CNT_W'(i + 1)) st_d.start[i] = 1'b1;
            end
            if (close_lat > rem_dec) st_d.rem = close_lat;
        end
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_act = st_q.act;

    AST_OPEN_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.act) |-> $past(st_q.start[0])); // R4
    AST_REM_COVERS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !flush) |=> (st_q.rem >= $past(close_lat))); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!st_q.act && st_q.start == '0)); // R10
endmodule

// File: rtl/dodt_sel.sv
`timescale 1ns/1ps
module dodt_sel #(
    parameter int WL_W    = 6,
    parameter int LAT_W   = 5,
    parameter int WL_MIN  = 5,
    parameter int WL_MAX  = 24,
    parameter int LAT_MAX = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_nom_code,
    input  logic [2:0]       cfg_wr_code,
    input  logic [2:0]       cfg_park_code,
    input  logic [WL_W-1:0]  cfg_wlat,
    input  logic [1:0]       cfg_burst_mode,
    input  logic             cfg_crc_en,
    input  logic             cfg_pre2_en,
    input  logic             cfg_dll_off,
    input  logic [LAT_W-1:0] cfg_on_lat,
    input  logic [LAT_W-1:0] cfg_off_lat,
    input  logic             wr_cmd,
    input  logic             wr_bc4,
    input  logic             odt_pin,
    output logic [2:0]       rtt_code_o,
    output logic [1:0]       rtt_src_o,
    output logic             cfg_err_o
);
    import dodt_pkg::*;

    localparam int DEPTH = WL_MAX + 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] open_lat;
    logic [CNT_W-1:0] close_lat;
    logic             cfg_err;
    logic             fire;
    logic             win_act;
    logic             nom_on;
    rtt_src_e         src_sel;
    logic [2:0]       code_sel;

    dodt_lat_calc #(
        .WL_W(WL_W), .LAT_W(LAT_W), .WL_MIN(WL_MIN), .WL_MAX(WL_MAX),
        .LAT_MAX(LAT_MAX), .CNT_W(CNT_W)
    ) u_lat (
        .cfg_wlat(cfg_wlat), .cfg_burst_mode(cfg_burst_mode), .wr_bc4(wr_bc4),
        .cfg_crc_en(cfg_crc_en), .cfg_pre2_en(cfg_pre2_en),
        .cfg_on_lat(cfg_on_lat), .cfg_off_lat(cfg_off_lat),
        .open_lat(open_lat), .close_lat(close_lat), .cfg_err(cfg_err)
    );

    dodt_pin_delay #(.LAT_W(LAT_W), .LAT_MAX(LAT_MAX)) u_pin (
        .clk(clk), .rst_n(rst_n), .odt_pin(odt_pin),
        .cfg_on_lat(cfg_on_lat), .cfg_off_lat(cfg_off_lat), .nom_on(nom_on)
    );

    assign fire = wr_cmd & ~cfg_err & ~cfg_dll_off & (cfg_wr_code != 3'd0);

    dodt_wr_window #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .fire(fire), .flush(cfg_dll_off),
        .open_lat(open_lat), .close_lat(close_lat), .win_act(win_act)
    );

    always_comb begin
        if (win_act) begin
            src_sel  = SRC_WR;
            code_sel = cfg_wr_code;
        end else if (nom_on) begin
            src_sel  = SRC_NOM;
            code_sel = cfg_nom_code;
        end else begin
            src_sel  = SRC_PARK;
            code_sel = cfg_park_code;
        end
        if (code_sel == 3'd0) src_sel = SRC_OFF;
    end

    assign rtt_code_o = code_sel;
    assign rtt_src_o  = src_sel;
    assign cfg_err_o  = cfg_err;

    AST_WR_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rtt_src_o == SRC_WR) |-> (rtt_code_o == cfg_wr_code)); // R1
    AST_DLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dll_off |=> (rtt_src_o != SRC_WR)); // R10
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rtt_src_o == SRC_OFF) |-> (rtt_code_o == 3'd0)); // R12
    AST_ERR_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !fire); // R11
endmodule

// File: tb/dodt_sel_bench.sv
`timescale 1ns/1ps
module dodt_sel_bench;
    localparam int CYC = 8;
    localparam logic [2:0] NOMC = 3'd1, WRC = 3'd6, PARKC = 3'd3;
    localparam logic [1:0] S_OFF = 2'd0, S_NOM = 2'd1, S_WR = 2'd2, S_PARK = 2'd3;

    logic clk = 1'b0;
    logic rst_n;
    logic [2:0] cfg_nom_code, cfg_wr_code, cfg_park_code;
    logic [5:0] cfg_wlat;
    logic [1:0] cfg_burst_mode;
    logic cfg_crc_en, cfg_pre2_en, cfg_dll_off;
    logic [4:0] cfg_on_lat, cfg_off_lat;
    logic wr_cmd, wr_bc4, odt_pin;
    logic [2:0] rtt_code_o;
    logic [1:0] rtt_src_o;
    logic cfg_err_o;
    int n_checks = 0;
    int n_errors = 0;

    always #(CYC/2) clk = ~clk;

    dodt_sel u_dodt_sel (
        .clk(clk), .rst_n(rst_n), .cfg_nom_code(cfg_nom_code), .cfg_wr_code(cfg_wr_code),
        .cfg_park_code(cfg_park_code), .cfg_wlat(cfg_wlat), .cfg_burst_mode(cfg_burst_mode),
        .cfg_crc_en(cfg_crc_en), .cfg_pre2_en(cfg_pre2_en), .cfg_dll_off(cfg_dll_off),
        .cfg_on_lat(cfg_on_lat), .cfg_off_lat(cfg_off_lat), .wr_cmd(wr_cmd), .wr_bc4(wr_bc4),
        .odt_pin(odt_pin), .rtt_code_o(rtt_code_o), .rtt_src_o(rtt_src_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string req, input logic [2:0] ec, input logic [1:0] es);
        n_checks++;
        if (rtt_code_o !== ec || rtt_src_o !== es) begin
            n_errors++;
            $display("FAIL %s: code=%0d src=%0d expected code=%0d src=%0d",
                     req, rtt_code_o, rtt_src_o, ec, es);
        end
    endtask

    task automatic chk_err(input string req, input logic exp);
        n_checks++;
        if (cfg_err_o !== exp) begin
            n_errors++;
            $display("FAIL %s: err=%0d expected %0d", req, cfg_err_o, exp);
        end
    endtask

    // write sampled at edge E0; sample j taken at negedge after edge E(j-1)
    task automatic watch_write(input bit bc4, input int open_e, input int close_e,
                               input bit exp_win, input string req);
        @(negedge clk); wr_cmd = 1'b1; wr_bc4 = bc4;
        @(negedge clk); wr_cmd = 1'b0; wr_bc4 = 1'b0;
        for (int j = 1; j <= close_e + 2; j++) begin
            if (exp_win && j > open_e && j <= close_e) chk(req, WRC, S_WR);
            else chk(req, PARKC, S_PARK);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 during reset", PARKC, S_PARK);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 R1 after reset", PARKC, S_PARK);
        chk_err("R11 legal default", 1'b0);
    endtask

    task automatic t_bursts();
        cfg_burst_mode = 2'b00;
        watch_write(1'b1, 7, 13, 1'b1, "R4 R5 full burst ignores flag");
        cfg_burst_mode = 2'b01;
        watch_write(1'b0, 7, 11, 1'b1, "R5 R6 fixed chop");
        cfg_burst_mode = 2'b10;
        watch_write(1'b1, 7, 11, 1'b1, "R6 per-command chop");
        watch_write(1'b0, 7, 13, 1'b1, "R6 per-command full");
        cfg_burst_mode = 2'b00;
        cfg_wlat = 6'd12;
        watch_write(1'b0, 10, 16, 1'b1, "R4 latency 12");
        cfg_wlat = 6'd9;
    endtask

    task automatic t_extras();
        cfg_pre2_en = 1'b1;
        watch_write(1'b0, 7, 14, 1'b1, "R7 preamble");
        cfg_crc_en = 1'b1;
        cfg_burst_mode = 2'b01;
        watch_write(1'b0, 7, 13, 1'b1, "R7 preamble plus crc");
        cfg_pre2_en = 1'b0;
        cfg_burst_mode = 2'b00;
        watch_write(1'b0, 7, 14, 1'b1, "R7 crc");
        cfg_crc_en = 1'b0;
    endtask

    task automatic t_overlap();
        // full bursts at E0 and E2: open 8, close 15
        @(negedge clk); wr_cmd = 1'b1;
        @(negedge clk); wr_cmd = 1'b0;
        for (int j = 1; j <= 18; j++) begin
            if (j >= 8 && j <= 15) chk("R8 later end", WRC, S_WR);
            else chk("R8 later end", PARKC, S_PARK);
            wr_cmd = (j == 2);
            @(negedge clk);
        end
        // full at E0, chop at E1: window stays until 13
        cfg_burst_mode = 2'b10;
        @(negedge clk); wr_cmd = 1'b1; wr_bc4 = 1'b0;
        @(negedge clk); wr_cmd = 1'b1; wr_bc4 = 1'b1;
        @(negedge clk); wr_cmd = 1'b0; wr_bc4 = 1'b0;
        for (int j = 2; j <= 16; j++) begin
            if (j >= 8 && j <= 13) chk("R8 keep earlier longer end", WRC, S_WR);
            else chk("R8 keep earlier longer end", PARKC, S_PARK);
            @(negedge clk);
        end
        cfg_burst_mode = 2'b00;
    endtask

    task automatic t_disabled();
        cfg_wr_code = 3'd0;
        watch_write(1'b0, 7, 13, 1'b0, "R9 zero write code");
        cfg_wr_code = WRC;
    endtask

    task automatic t_dll();
        @(negedge clk); wr_cmd = 1'b1;
        @(negedge clk); wr_cmd = 1'b0;
        for (int j = 1; j <= 20; j++) begin
            if (j >= 8 && j <= 9) chk("R10 dll off", WRC, S_WR);
            else chk("R10 dll off", PARKC, S_PARK);
            cfg_dll_off = (j == 9);
            wr_cmd = (j == 9);
            @(negedge clk);
        end
    endtask

    task automatic t_err();
        cfg_wlat = 6'd4;
        #1 chk_err("R11 latency low", 1'b1);
        watch_write(1'b0, 2, 8, 1'b0, "R11 write ignored");
        cfg_wlat = 6'd25;
        #1 chk_err("R11 latency high", 1'b1);
        cfg_wlat = 6'd9; cfg_on_lat = 5'd8; cfg_off_lat = 5'd7;
        #1 chk_err("R11 on above off", 1'b1);
        cfg_on_lat = 5'd25; cfg_off_lat = 5'd25;
        #1 chk_err("R11 off above max", 1'b1);
        cfg_on_lat = 5'd7; cfg_off_lat = 5'd7;
        #1 chk_err("R11 restored", 1'b0);
    endtask

    task automatic t_nominal();
        cfg_on_lat = 5'd3; cfg_off_lat = 5'd5;
        @(negedge clk); odt_pin = 1'b1;
        @(negedge clk);
        for (int j = 1; j <= 17; j++) begin
            if (j >= 4 && j <= 15) chk("R3 R1 nominal delay", NOMC, S_NOM);
            else chk("R3 R1 nominal delay", PARKC, S_PARK);
            if (j == 10) odt_pin = 1'b0;
            @(negedge clk);
        end
        cfg_on_lat = 5'd7; cfg_off_lat = 5'd7;
    endtask

    task automatic t_off();
        cfg_nom_code = 3'd0;
        odt_pin = 1'b1;
        repeat (9) @(negedge clk);
        chk("R12 nominal code zero", 3'd0, S_OFF);
        odt_pin = 1'b0;
        repeat (9) @(negedge clk);
        cfg_nom_code = NOMC;
        cfg_park_code = 3'd0;
        #1 chk("R12 park code zero", 3'd0, S_OFF);
        cfg_park_code = PARKC;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    endtask

    initial begin
        cfg_nom_code = NOMC; cfg_wr_code = WRC; cfg_park_code = PARKC;
        cfg_wlat = 6'd9; cfg_burst_mode = 2'b00;
        cfg_crc_en = 1'b0; cfg_pre2_en = 1'b0; cfg_dll_off = 1'b0;
        cfg_on_lat = 5'd7; cfg_off_lat = 5'd7;
        wr_cmd = 1'b0; wr_bc4 = 1'b0; odt_pin = 1'b0; rst_n = 1'b0;
        t_reset();
        t_bursts();
        t_extras();
        t_overlap();
        t_disabled();
        t_dll();
        t_err();
        t_nominal();
        t_off();
        summary();
        $finish;
    end

    initial begin
        #(CYC * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end
endmodule